// File: doc/BRIEF.md
# Slice-Aware Decimating Equalizer FIR

This block filters the sample stream of a time-interleaved ADC. The stream arrives several samples per clock on a parallel lane bus. The block computes the convolution only at every DECIM-th sample position and skips the positions in between. Each convolution uses the coefficient set that belongs to the ADC slice that captured the sample at that output position. One filter therefore corrects the per-slice gain and phase, rejects aliases and decimates, all at the output rate.

Coefficient sets are loaded one tap at a time into a shadow store. A commit strobe copies the whole shadow store into the active store, so the set in use never changes part-way through a beat. Each output sample carries the index of its slice. The slice of sample position zero is taken from a phase input while reset is held.

Top module: `slice_eq_decim_fir`

## Requirements
- R1: Sample position n = b*LANES + k is lane k (bits [k*DW +: DW], lane 0 the earliest) of the b-th beat accepted since reset. Samples before reset release count as zero. The output at position n is the sum over t = 0..TAPS-1 of h[s][t] * x[n-t], where s is the slice of position n.
- R2: Each accepted beat b yields LANES/DECIM outputs, at positions b*LANES + q*DECIM, placed on out_data[q*OW +: OW]. A cycle with in_valid low leaves the sample history untouched, so gaps between beats do not change any result.
- R3: The full-precision sum is rounded as floor((sum + 2^(SHIFT-1)) / 2^SHIFT) and then clamped to the range [-2^(OW-1), 2^(OW-1)-1].
- R4: Position n belongs to slice (init_slice + n) mod SLICES, where init_slice is the value held while rst_n is low. The slice of output q appears on out_slice[q*SW +: SW].
- R5: Every output uses only the active coefficient set of its own slice. A write with cw_en high stores cw_data as tap cw_tap of slice cw_slice in the shadow store.
- R6: Shadow writes have no effect on outputs until commit is pulsed. The commit edge copies every shadow tap into the active store, and a beat accepted in the commit cycle still uses the previous active set.
- R7: After reset both coefficient stores and the sample history are zero. out_valid, out_data and out_slice are all zero.
- R8: out_valid is high exactly in the cycle after an accepted beat. out_data and out_slice change only then and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_slice | input | SW | Slice of sample position zero, sampled during reset |
| in_valid | input | 1 | Lane bus carries a beat |
| in_data | input | LANES*DW | Signed samples, lane 0 in the low bits and the earliest |
| cw_en | input | 1 | Shadow coefficient write strobe |
| cw_slice | input | SW | Slice of the written tap |
| cw_tap | input | TW | Tap index of the written tap |
| cw_data | input | CW | Signed coefficient, 2^SHIFT equals unity |
| commit | input | 1 | Copy the shadow store into the active store |
| out_valid | output | 1 | Decimated outputs are new this cycle |
| out_data | output | (LANES/DECIM)*OW | Signed rounded and clamped outputs |
| out_slice | output | (LANES/DECIM)*SW | Slice index of each output |

## Verification
If the slice phase register is off by one, every out_slice tag is wrong on the first valid output after the fault. The data then follows the wrong coefficient set on that same beat. If the history register corrupts or shifts during an idle cycle, the next beat's outputs differ, because every output window reaches TAPS-1 samples back. If the active store is wrong, mismatches appear only on outputs whose slice uses the damaged taps, so the bench spreads random coefficients over all slices and compares all lanes on every clock.

// File: rtl/sefir_pkg.sv
`timescale 1ns/1ps
package sefir_pkg;
   // modular add of two values already below m
   function automatic int wrap_add(input int a, input int b, input int m);
      int s;
      s = a + b;
      if (s >= m) s = s - m;
      return s;
   endfunction

   function automatic int bits_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/sefir_coef_bank.sv
`timescale 1ns/1ps
module sefir_coef_bank
   import sefir_pkg::*;
#(
   parameter int SLICES = 4,
   parameter int TAPS   = 8,
   parameter int CW     = 16,
   localparam int SW    = bits_for(SLICES),
   localparam int TW    = bits_for(TAPS),
   localparam int NENT  = SLICES * TAPS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [SW-1:0]        wr_slice_i,
   input  logic [TW-1:0]        wr_tap_i,
   input  logic [CW-1:0]        wr_data_i,
   input  logic                 commit_i,
   output logic [NENT*CW-1:0]   act_o
);
   logic [CW-1:0] shd_q [NENT];
   logic [CW-1:0] act_q [NENT];
   logic          wr_ok;
   int            wr_idx;

   assign wr_ok  = (int'(wr_slice_i) < SLICES) && (int'(wr_tap_i) < TAPS);
   assign wr_idx = int'(wr_slice_i) * TAPS + int'(wr_tap_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NENT; i++) begin
            shd_q[i] <= '0;
            act_q[i] <= '0;
         end
      end else begin
         if (wr_en_i && wr_ok) shd_q[wr_idx] <= wr_data_i;
         if (commit_i) begin
            for (int i = 0; i < NENT; i++) act_q[i] <= shd_q[i];
         end
      end
   end

   for (genvar e = 0; e < NENT; e++) begin : g_flat
      assign act_o[e*CW +: CW] = act_q[e];
   end

   // R6: the active set moves only on a commit edge
   p_hold_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(act_o));
endmodule

// File: rtl/sefir_window.sv
`timescale 1ns/1ps
module sefir_window
   import sefir_pkg::*;
#(
   parameter int LANES  = 4,
   parameter int TAPS   = 8,
   parameter int DECIM  = 2,
   parameter int DW     = 12,
   localparam int HIST  = TAPS - 1,
   localparam int WN    = HIST + LANES,
   localparam int OUTS  = LANES / DECIM,
   localparam int USE   = HIST + (OUTS - 1) * DECIM + 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv_i,
   input  logic [LANES*DW-1:0]  lanes_i,
   output logic [USE*DW-1:0]    wnd_o
);
   logic [HIST*DW-1:0] hist_q;
   logic [WN*DW-1:0]   full;

   // index i holds the sample HIST-i positions before lane 0
   assign full  = {lanes_i, hist_q};
   assign wnd_o = full[USE*DW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n)     hist_q <= '0;
      else if (adv_i) hist_q <= full[LANES*DW +: HIST*DW];
   end

   // R2: idle cycles leave the history untouched
   p_hist_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(hist_q));
endmodule

// File: rtl/sefir_phase.sv
`timescale 1ns/1ps
module sefir_phase
   import sefir_pkg::*;
#(
   parameter int SLICES = 4,
   parameter int LANES  = 4,
   parameter int DECIM  = 2,
   localparam int SW    = bits_for(SLICES),
   localparam int OUTS  = LANES / DECIM,
   localparam int STEP  = LANES % SLICES
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SW-1:0]       init_i,
   input  logic                adv_i,
   output logic [OUTS*SW-1:0]  tags_o
);
   logic [SW-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     base_q <= SW'(int'(init_i) % SLICES);
      else if (adv_i) base_q <= SW'(wrap_add(int'(base_q), STEP, SLICES));
   end

   for (genvar q = 0; q < OUTS; q++) begin : g_tag
      assign tags_o[q*SW +: SW] =
         SW'(wrap_add(int'(base_q), (q * DECIM) % SLICES, SLICES));
   end

   // R4: the slice phase moves only with accepted beats
   p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(base_q));
endmodule

// File: rtl/sefir_mac.sv
`timescale 1ns/1ps
module sefir_mac
   import sefir_pkg::*;
#(
   parameter int TAPS   = 8,
   parameter int SLICES = 4,
   parameter int DW     = 12,
   parameter int CW     = 16,
   parameter int OW     = 12,
   parameter int SHIFT  = 13,
   localparam int SW    = bits_for(SLICES),
   localparam int PW    = DW + CW,
   localparam int AW    = DW + CW + bits_for(TAPS) + 1
) (
   input  logic [TAPS*DW-1:0]         wnd_i,
   input  logic [SLICES*TAPS*CW-1:0]  coef_i,
   input  logic [SW-1:0]              slice_i,
   output logic [OW-1:0]              y_o
);
   localparam logic signed [AW-1:0] MAXV = {{(AW-OW+1){1'b0}}, {(OW-1){1'b1}}};
   localparam logic signed [AW-1:0] MINV = {{(AW-OW+1){1'b1}}, {(OW-1){1'b0}}};

   logic signed [DW-1:0] xs;
   logic signed [CW-1:0] cs;
   logic signed [PW-1:0] pr;
   logic signed [AW-1:0] acc, rnd, shr;

   always_comb begin
      acc = '0;
      for (int t = 0; t < TAPS; t++) begin
         // window slot TAPS-1 is the output position itself
         xs  = wnd_i[(TAPS-1-t)*DW +: DW];
         cs  = coef_i[(int'(slice_i)*TAPS + t)*CW +: CW];
         pr  = xs * cs;
         acc = acc + AW'(pr);
      end
      rnd = acc + (AW'(1) <<< (SHIFT-1));
      shr = rnd >>> SHIFT;
      if (shr > MAXV)      y_o = MAXV[OW-1:0];
      else if (shr < MINV) y_o = MINV[OW-1:0];
      else                 y_o = shr[OW-1:0];
   end
endmodule

// File: rtl/slice_eq_decim_fir.sv
`timescale 1ns/1ps
module slice_eq_decim_fir
   import sefir_pkg::*;
#(
   parameter int TAPS   = 8,
   parameter int SLICES = 4,
   parameter int DECIM  = 2,
   parameter int LANES  = 4,
   parameter int DW     = 12,
   parameter int CW     = 16,
   parameter int OW     = 12,
   parameter int SHIFT  = 13,
   localparam int SW    = bits_for(SLICES),
   localparam int TW    = bits_for(TAPS),
   localparam int OUTS  = LANES / DECIM
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SW-1:0]        init_slice,
   input  logic                 in_valid,
   input  logic [LANES*DW-1:0]  in_data,
   input  logic                 cw_en,
   input  logic [SW-1:0]        cw_slice,
   input  logic [TW-1:0]        cw_tap,
   input  logic [CW-1:0]        cw_data,
   input  logic                 commit,
   output logic                 out_valid,
   output logic [OUTS*OW-1:0]   out_data,
   output logic [OUTS*SW-1:0]   out_slice
);
   localparam int AW   = DW + CW + bits_for(TAPS) + 1;
   localparam int USE  = TAPS - 1 + (OUTS - 1) * DECIM + 1;
   localparam int STEP = LANES % SLICES;

   if (LANES % DECIM != 0) begin : g_chk_ratio
      $error("LANES must be a multiple of DECIM");
   end
   if (TAPS < 2) begin : g_chk_taps
      $error("TAPS must be at least 2");
   end
   if (SHIFT < 1 || AW <= OW) begin : g_chk_width
      $error("SHIFT must be positive and the sum wider than the output");
   end

   logic [SLICES*TAPS*CW-1:0] coef_act;
   logic [USE*DW-1:0]         wnd;
   logic [OUTS*SW-1:0]        tags;
   logic [OUTS*OW-1:0]        y;

   sefir_coef_bank #(.SLICES(SLICES), .TAPS(TAPS), .CW(CW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en_i(cw_en), .wr_slice_i(cw_slice),
      .wr_tap_i(cw_tap), .wr_data_i(cw_data), .commit_i(commit),
      .act_o(coef_act));

   sefir_window #(.LANES(LANES), .TAPS(TAPS), .DECIM(DECIM), .DW(DW)) u_wnd (
      .clk(clk), .rst_n(rst_n), .adv_i(in_valid), .lanes_i(in_data),
      .wnd_o(wnd));

   sefir_phase #(.SLICES(SLICES), .LANES(LANES), .DECIM(DECIM)) u_phase (
      .clk(clk), .rst_n(rst_n), .init_i(init_slice), .adv_i(in_valid),
      .tags_o(tags));

   for (genvar q = 0; q < OUTS; q++) begin : g_out
      sefir_mac #(.TAPS(TAPS), .SLICES(SLICES), .DW(DW), .CW(CW), .OW(OW),
                  .SHIFT(SHIFT)) u_mac (
         .wnd_i(wnd[q*DECIM*DW +: TAPS*DW]),
         .coef_i(coef_act),
         .slice_i(tags[q*SW +: SW]),
         .y_o(y[q*OW +: OW]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_slice <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data  <= y;
            out_slice <= tags;
         end
      end
   end

   // R8: an idle input cycle produces no output and keeps the last result
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_slice)));

   // R4: back-to-back beats advance the first tag by LANES modulo SLICES
   p_beat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |->
         (int'(out_slice[SW-1:0]) ==
          wrap_add(int'($past(out_slice[SW-1:0])), STEP, SLICES)));
endmodule

// File: tb/slice_eq_decim_fir_tb_top.sv
`timescale 1ns/1ps
module slice_eq_decim_fir_tb_top;
   localparam int TAPS = 8, SLC = 4, DECIM = 2, LANES = 4;
   localparam int DW = 12, CW = 16, OW = 12, SHIFT = 13;
   localparam int SW = 2, TW = 3, OUTS = LANES / DECIM;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [SW-1:0] init_slice = '0;
   logic in_valid = 1'b0;
   logic [LANES*DW-1:0] in_data = '0;
   logic cw_en = 1'b0;
   logic [SW-1:0] cw_slice = '0;
   logic [TW-1:0] cw_tap = '0;
   logic [CW-1:0] cw_data = '0;
   logic commit = 1'b0;
   logic out_valid;
   logic [OUTS*OW-1:0] out_data;
   logic [OUTS*SW-1:0] out_slice;

   always #10 clk = ~clk;

   slice_eq_decim_fir #(.TAPS(TAPS), .SLICES(SLC), .DECIM(DECIM), .LANES(LANES),
      .DW(DW), .CW(CW), .OW(OW), .SHIFT(SHIFT)) dut_i (
      .clk(clk), .rst_n(rst_n), .init_slice(init_slice), .in_valid(in_valid),
      .in_data(in_data), .cw_en(cw_en), .cw_slice(cw_slice), .cw_tap(cw_tap),
      .cw_data(cw_data), .commit(commit), .out_valid(out_valid),
      .out_data(out_data), .out_slice(out_slice));

   // behavioural reference state
   int xs[$];
   int sh[SLC][TAPS];
   int act[SLC][TAPS];
   int init_ph, init_val;
   int e_valid;
   int e_data[OUTS];
   int e_slice[OUTS];
   int lane_val[LANES];
   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   function automatic int predict(input int n);
      longint acc, r;
      int s, x;
      s = (init_ph + n) % SLC;
      acc = 0;
      for (int t = 0; t < TAPS; t++) begin
         x = (n - t >= 0) ? xs[n - t] : 0;
         acc += longint'(act[s][t]) * longint'(x);
      end
      r = (acc + (longint'(1) <<< (SHIFT - 1))) >>> SHIFT;
      if (r > (2 ** (OW - 1)) - 1) r = (2 ** (OW - 1)) - 1;
      if (r < -(2 ** (OW - 1))) r = -(2 ** (OW - 1));
      return int'(r);
   endfunction

   task automatic compare(input string req);
      int got;
      n_cmp++;
      if (int'(out_valid) != e_valid) begin
         n_bad++;
         $display("FAIL %s R8 out_valid got %0d exp %0d", req, out_valid, e_valid);
      end
      for (int q = 0; q < OUTS; q++) begin
         got = int'($signed(out_data[q*OW +: OW]));
         n_cmp++;
         if (got != e_data[q]) begin
            n_bad++;
            $display("FAIL %s R1/R3 lane %0d data got %0d exp %0d", req, q, got, e_data[q]);
         end
         got = int'(out_slice[q*SW +: SW]);
         n_cmp++;
         if (got != e_slice[q]) begin
            n_bad++;
            $display("FAIL %s R4 lane %0d slice got %0d exp %0d", req, q, got, e_slice[q]);
         end
      end
   endtask

   // drive one cycle at a falling edge, update the model, check after the next edge
   task automatic cycle(input bit v, input bit r, input bit we, input int ws,
                        input int wt, input int wd, input bit cm, input string req);
      rst_n = r; in_valid = v; cw_en = we; commit = cm;
      cw_slice = SW'(ws); cw_tap = TW'(wt); cw_data = CW'(wd);
      init_slice = SW'(init_val);
      for (int k = 0; k < LANES; k++) in_data[k*DW +: DW] = DW'(lane_val[k]);
      if (!r) begin
         e_valid = 0;
         for (int q = 0; q < OUTS; q++) begin e_data[q] = 0; e_slice[q] = 0; end
         xs.delete();
         for (int s = 0; s < SLC; s++)
            for (int t = 0; t < TAPS; t++) begin sh[s][t] = 0; act[s][t] = 0; end
         init_ph = init_val;
      end else begin
         if (v) begin
            int base;
            base = xs.size();
            for (int k = 0; k < LANES; k++) xs.push_back(lane_val[k]);
            for (int q = 0; q < OUTS; q++) begin
               e_data[q]  = predict(base + q * DECIM);
               e_slice[q] = (init_ph + base + q * DECIM) % SLC;
            end
            e_valid = 1;
         end else begin
            e_valid = 0;
         end
         if (cm) begin
            for (int s = 0; s < SLC; s++)
               for (int t = 0; t < TAPS; t++) act[s][t] = sh[s][t];
         end
         if (we) sh[ws][wt] = wd;
      end
      @(negedge clk);
      compare(req);
   endtask

   task automatic rand_lanes();
      for (int k = 0; k < LANES; k++) lane_val[k] = int'($urandom_range(0, 4095)) - 2048;
   endtask

   task automatic beat(input string req);
      rand_lanes();
      cycle(1'b1, 1'b1, 1'b0, 0, 0, 0, 1'b0, req);
   endtask

   task automatic wr(input int s, input int t, input int d, input bit v, input string req);
      rand_lanes();
      cycle(v, 1'b1, 1'b1, s, t, d, 1'b0, req);
   endtask

   task automatic do_commit(input bit v, input string req);
      rand_lanes();
      cycle(v, 1'b1, 1'b0, 0, 0, 0, 1'b1, req);
   endtask

   task automatic do_reset(input int ph, input string req);
      init_val = ph;
      rand_lanes();
      cycle(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0, req);
      cycle(1'b0, 1'b0, 1'b0, 0, 0, 0, 1'b0, req);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed));
      for (int k = 0; k < LANES; k++) lane_val[k] = 0;
      @(negedge clk);
      // R7: reset state, init phase 3
      do_reset(3, "R7");
      // R7/R4: zero coefficients give zero outputs with tags from phase 3
      for (int i = 0; i < 6; i++) beat("R7/R4");

      // R6/R5: shadow writes alongside beats leave outputs at zero
      for (int s = 0; s < SLC; s++)
         for (int t = 0; t < TAPS; t++)
            wr(s, t, (s + 1) * 1000 - t * 300, (t % 2) == 0, "R6");
      for (int i = 0; i < 4; i++) beat("R6");
      // R6: beat in the commit cycle still uses the old (zero) set
      do_commit(1'b1, "R6");
      for (int i = 0; i < 10; i++) beat("R1/R5");

      // R3: unity, half, minus half, double and delayed taps for rounding and clamping
      for (int s = 0; s < SLC; s++)
         for (int t = 0; t < TAPS; t++) wr(s, t, 0, 1'b0, "R3");
      wr(0, 0, 4096, 1'b0, "R3");
      wr(1, 0, 16384, 1'b0, "R3");
      wr(2, 0, -4096, 1'b0, "R3");
      wr(3, 1, 8192, 1'b0, "R3");
      do_commit(1'b0, "R3");
      for (int i = 0; i < 20; i++) beat("R3");
      for (int i = 0; i < 6; i++) begin
         for (int k = 0; k < LANES; k++) lane_val[k] = (i % 2 == 0) ? 2047 : -2048;
         cycle(1'b1, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R3");
      end

      // R2: random coefficients and random gaps between beats
      for (int s = 0; s < SLC; s++)
         for (int t = 0; t < TAPS; t++)
            wr(s, t, int'($urandom_range(0, 8191)) - 4096, 1'b0, "R2");
      do_commit(1'b0, "R2");
      for (int i = 0; i < 300; i++) begin
         rand_lanes();
         cycle($urandom_range(0, 2) != 0, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R2");
      end

      // R4: new phase after a mid-run reset
      do_reset(1, "R4/R7");
      for (int i = 0; i < 4; i++) beat("R4");
      for (int s = 0; s < SLC; s++)
         for (int t = 0; t < TAPS; t++)
            wr(s, t, int'($urandom_range(0, 65535)) - 32768, 1'b1, "R4");
      do_commit(1'b1, "R4");
      for (int i = 0; i < 40; i++) beat("R4/R1");

      // R1/R5/R6: long random run with writes and commits interleaved
      for (int i = 0; i < 2000; i++) begin
         int sel;
         sel = int'($urandom_range(0, 19));
         if (sel == 0) do_commit($urandom_range(0, 1) == 1, "R6");
         else if (sel < 6)
            wr(int'($urandom_range(0, SLC - 1)), int'($urandom_range(0, TAPS - 1)),
               (sel < 3) ? int'($urandom_range(0, 65535)) - 32768
                         : int'($urandom_range(0, 4095)) - 2048,
               $urandom_range(0, 1) == 1, "R5");
         else begin
            rand_lanes();
            cycle($urandom_range(0, 3) != 0, 1'b1, 1'b0, 0, 0, 0, 1'b0, "R1");
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule